// File: doc/BRIEF.md
# Trace Cache with Fill Unit

This block supplies instructions in the order a program actually ran them, not in the order they sit in memory. A fill side is fed the retired instruction stream one instruction per cycle. Each instruction arrives with its address, its encoding, a flag saying whether it was a taken branch, and the address of the instruction that ran after it. A fill buffer gathers these into a segment. When the segment can grow no further, the whole segment is written at once into a small direct-mapped array of trace lines. Each line is tagged with the address of the segment's first instruction.

A fetch side presents an address and gets back a registered answer. On a hit, the answer carries every instruction of the stored segment as one packed bundle, the number of instructions in it, and the address to fetch after the segment. A single line can therefore carry instructions from several non-adjacent code regions joined by taken branches. A flush input throws away all stored lines and the segment under construction.

Top module: `trace_cache`

## Requirements
- R1: After reset, and on every cycle whose registered result is a miss, `hit_o` is 0 and `hit_count_o`, `hit_insns_o` and `hit_next_pc_o` are all zero. No line is valid after reset.
- R2: A fetch address sampled at a clock edge produces its result right after that edge. It is a hit only if the line at its index is valid and that line's stored start address equals the full fetch address. Without a fetch request the result is a miss.
- R3: On a hit, slot k of the bundle (bits `k*INSN_W +: INSN_W`, slot 0 in the low bits) holds the k-th instruction of the segment in execution order. `hit_count_o` gives the number of instructions, from 1 to `SLOTS`. Slots at or above the count read as zero.
- R4: A segment is closed and written as soon as it holds `SLOTS` (default 8) instructions.
- R5: A segment is also closed by its `MAX_TAKEN`-th (default 3rd) taken branch. That branch is the segment's last instruction.
- R6: A segment that is still being built is never returned by a fetch.
- R7: The next-fetch address of a line is the successor address given with the segment's last instruction.
- R8: The line index is `pc[IDX_W+1:2]` (bits 5:2 for 16 lines). A closed segment overwrites whatever line its start address maps to, so an older segment with a different start address but the same index then misses.
- R9: A fetch presented in the same cycle as the write of its line returns the line's contents from before the write.
- R10: A flush invalidates every line and drops the partial segment. An instruction offered in the flush cycle is dropped. A fetch in the flush cycle still sees the contents from before the flush, and fetches afterwards miss until new segments are written.
- R11: The first instruction accepted after a segment closes, or after a flush, starts a new segment, and its address becomes the new line's tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Invalidate all lines and drop the open segment |
| fill_valid_i | input | 1 | An executed instruction is offered to the fill buffer |
| fill_pc_i | input | PC_W | Address of the offered instruction |
| fill_insn_i | input | INSN_W | Encoding of the offered instruction |
| fill_taken_i | input | 1 | The offered instruction is a taken branch |
| fill_next_pc_i | input | PC_W | Address of the instruction that ran after it |
| fetch_valid_i | input | 1 | A lookup is requested |
| fetch_pc_i | input | PC_W | Lookup address |
| hit_o | output | 1 | Registered lookup hit |
| hit_count_o | output | $clog2(SLOTS+1) | Instructions in the returned segment |
| hit_insns_o | output | SLOTS*INSN_W | Returned instruction bundle, slot 0 lowest |
| hit_next_pc_o | output | PC_W | Next fetch address after the segment |

## Verification
Two timings govern every result. A lookup's answer is due immediately after the clock edge that samples the fetch address. A segment's write lands on the edge that accepts its closing instruction, so a lookup of that line shows the new contents only from the next request onward. The bench drives inputs on the falling edge. Before each rising edge it computes the expected answer from its own model of the stored lines, and only then applies that cycle's fill or flush to the model. It compares the outputs one nanosecond after the rising edge. This ordering reproduces the read-old-contents rule for a write and a lookup in the same cycle, and for a flush and a lookup in the same cycle, without any special case.

// File: rtl/tc_pkg.sv
package tc_pkg;

  localparam int unsigned DEF_PC_W      = 32;
  localparam int unsigned DEF_INSN_W    = 32;
  localparam int unsigned DEF_SLOTS     = 8;
  localparam int unsigned DEF_MAX_TAKEN = 3;
  localparam int unsigned DEF_LINES     = 16;

  // True when accepting one more instruction leaves the segment unable to grow.
  function automatic logic seg_full(input int unsigned held,
                                    input int unsigned taken_held,
                                    input logic        taken_now,
                                    input int unsigned slots,
                                    input int unsigned max_taken);
    return ((held + 1) >= slots) ||
           (taken_now && ((taken_held + 1) >= max_taken));
  endfunction

endpackage

// File: rtl/tc_fill_unit.sv
module tc_fill_unit #(
  parameter int unsigned PC_W      = 32,
  parameter int unsigned INSN_W    = 32,
  parameter int unsigned SLOTS     = 8,
  parameter int unsigned MAX_TAKEN = 3,
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned TK_W      = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    in_valid,
  input  logic [PC_W-1:0]         in_pc,
  input  logic [INSN_W-1:0]       in_insn,
  input  logic                    in_taken,
  input  logic [PC_W-1:0]         in_next_pc,
  output logic                    wr_en,
  output logic [PC_W-1:0]         wr_tag,
  output logic [CNT_W-1:0]        wr_count,
  output logic [SLOTS*INSN_W-1:0] wr_insns,
  output logic [PC_W-1:0]         wr_next,
  output logic [CNT_W-1:0]        held_count,
  output logic [TK_W-1:0]         held_taken
);
  import tc_pkg::*;

  logic [CNT_W-1:0]  held_q;
  logic [TK_W-1:0]   taken_q;
  logic [PC_W-1:0]   start_q;
  logic [INSN_W-1:0] slot_q [SLOTS];
  logic              accept;
  logic              closing;

  assign accept  = in_valid && !flush;
  assign closing = accept && seg_full(32'(held_q), 32'(taken_q), in_taken,
                                      SLOTS, MAX_TAKEN);

  assign wr_en      = closing;
  assign wr_tag     = (held_q == '0) ? in_pc : start_q;
  assign wr_count   = held_q + CNT_W'(1);
  assign wr_next    = in_next_pc;
  assign held_count = held_q;
  assign held_taken = taken_q;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    assign wr_insns[i*INSN_W +: INSN_W] =
      (CNT_W'(i) < held_q)  ? slot_q[i] :
      (CNT_W'(i) == held_q) ? in_insn   : '0;

    always_ff @(posedge clk) begin
      if (accept && !closing && held_q == CNT_W'(i)) slot_q[i] <= in_insn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      held_q  <= '0;
      taken_q <= '0;
      start_q <= '0;
    end else if (accept) begin
      if (closing) begin
        held_q  <= '0;
        taken_q <= '0;
      end else begin
        held_q  <= held_q + CNT_W'(1);
        taken_q <= taken_q + TK_W'(in_taken);
        if (held_q == '0) start_q <= in_pc;
      end
    end
  end

endmodule

// File: rtl/tc_line_array.sv
module tc_line_array #(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned INSN_W = 32,
  parameter int unsigned SLOTS  = 8,
  parameter int unsigned LINES  = 16,
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned IDX_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    wr_en,
  input  logic [PC_W-1:0]         wr_tag,
  input  logic [CNT_W-1:0]        wr_count,
  input  logic [SLOTS*INSN_W-1:0] wr_insns,
  input  logic [PC_W-1:0]         wr_next,
  input  logic                    rd_en,
  input  logic [PC_W-1:0]         rd_pc,
  output logic                    rd_hit,
  output logic [CNT_W-1:0]        rd_count,
  output logic [SLOTS*INSN_W-1:0] rd_insns,
  output logic [PC_W-1:0]         rd_next
);
  localparam int unsigned BUNDLE_W = SLOTS * INSN_W;

  function automatic logic [IDX_W-1:0] line_index(input logic [PC_W-1:0] pc);
    return pc[IDX_W+1:2];
  endfunction

  logic [LINES-1:0]    valid_q;
  logic [PC_W-1:0]     tag_mem  [LINES];
  logic [CNT_W-1:0]    cnt_mem  [LINES];
  logic [BUNDLE_W-1:0] ins_mem  [LINES];
  logic [PC_W-1:0]     next_mem [LINES];

  logic [IDX_W-1:0] widx;
  logic [IDX_W-1:0] ridx;
  logic             look_hit;

  assign widx     = line_index(wr_tag);
  assign ridx     = line_index(rd_pc);
  assign look_hit = rd_en && valid_q[ridx] && (tag_mem[ridx] == rd_pc);

  always_ff @(posedge clk) begin
    if (!rst_n || flush)  valid_q       <= '0;
    else if (wr_en)       valid_q[widx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      tag_mem[widx]  <= wr_tag;
      cnt_mem[widx]  <= wr_count;
      ins_mem[widx]  <= wr_insns;
      next_mem[widx] <= wr_next;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_hit   <= 1'b0;
      rd_count <= '0;
      rd_insns <= '0;
      rd_next  <= '0;
    end else begin
      rd_hit   <= look_hit;
      rd_count <= look_hit ? cnt_mem[ridx]  : '0;
      rd_insns <= look_hit ? ins_mem[ridx]  : '0;
      rd_next  <= look_hit ? next_mem[ridx] : '0;
    end
  end

endmodule

// File: rtl/trace_cache.sv
module trace_cache #(
  parameter int unsigned PC_W      = tc_pkg::DEF_PC_W,
  parameter int unsigned INSN_W    = tc_pkg::DEF_INSN_W,
  parameter int unsigned SLOTS     = tc_pkg::DEF_SLOTS,
  parameter int unsigned MAX_TAKEN = tc_pkg::DEF_MAX_TAKEN,
  parameter int unsigned LINES     = tc_pkg::DEF_LINES,
  localparam int unsigned CNT_W    = $clog2(SLOTS + 1),
  localparam int unsigned TK_W     = $clog2(MAX_TAKEN + 1),
  localparam int unsigned IDX_W    = $clog2(LINES),
  localparam int unsigned BUNDLE_W = SLOTS * INSN_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush_i,
  input  logic                fill_valid_i,
  input  logic [PC_W-1:0]     fill_pc_i,
  input  logic [INSN_W-1:0]   fill_insn_i,
  input  logic                fill_taken_i,
  input  logic [PC_W-1:0]     fill_next_pc_i,
  input  logic                fetch_valid_i,
  input  logic [PC_W-1:0]     fetch_pc_i,
  output logic                hit_o,
  output logic [CNT_W-1:0]    hit_count_o,
  output logic [BUNDLE_W-1:0] hit_insns_o,
  output logic [PC_W-1:0]     hit_next_pc_o
);

  // Named internal events, observed by the bound checker.
  logic                seg_write;
  logic [PC_W-1:0]     seg_tag;
  logic [CNT_W-1:0]    seg_count;
  logic [BUNDLE_W-1:0] seg_insns;
  logic [PC_W-1:0]     seg_next;
  logic [CNT_W-1:0]    fill_held;
  logic [TK_W-1:0]     fill_taken_held;

  tc_fill_unit #(
    .PC_W(PC_W), .INSN_W(INSN_W), .SLOTS(SLOTS), .MAX_TAKEN(MAX_TAKEN),
    .CNT_W(CNT_W), .TK_W(TK_W)
  ) u_fill (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush_i),
    .in_valid   (fill_valid_i),
    .in_pc      (fill_pc_i),
    .in_insn    (fill_insn_i),
    .in_taken   (fill_taken_i),
    .in_next_pc (fill_next_pc_i),
    .wr_en      (seg_write),
    .wr_tag     (seg_tag),
    .wr_count   (seg_count),
    .wr_insns   (seg_insns),
    .wr_next    (seg_next),
    .held_count (fill_held),
    .held_taken (fill_taken_held)
  );

  tc_line_array #(
    .PC_W(PC_W), .INSN_W(INSN_W), .SLOTS(SLOTS), .LINES(LINES),
    .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_lines (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush_i),
    .wr_en    (seg_write),
    .wr_tag   (seg_tag),
    .wr_count (seg_count),
    .wr_insns (seg_insns),
    .wr_next  (seg_next),
    .rd_en    (fetch_valid_i),
    .rd_pc    (fetch_pc_i),
    .rd_hit   (hit_o),
    .rd_count (hit_count_o),
    .rd_insns (hit_insns_o),
    .rd_next  (hit_next_pc_o)
  );

endmodule

// File: rtl/tc_checker.sv
module tc_checker #(
  parameter int unsigned SLOTS     = 8,
  parameter int unsigned MAX_TAKEN = 3,
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned TK_W      = 2,
  parameter int unsigned BUNDLE_W  = 256
) (
  input logic                clk,
  input logic                rst_n,
  input logic                flush_i,
  input logic                fetch_valid_i,
  input logic                hit_o,
  input logic [CNT_W-1:0]    hit_count_o,
  input logic [BUNDLE_W-1:0] hit_insns_o,
  input logic                seg_write,
  input logic [CNT_W-1:0]    fill_held,
  input logic [TK_W-1:0]     fill_taken_held
);

  logic flush_d;
  logic wrote_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flush_d <= 1'b0;
      wrote_q <= 1'b0;
    end else begin
      flush_d <= flush_i;
      if (seg_write && !flush_i) wrote_q <= 1'b1;
    end
  end

  assert_miss_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |-> (hit_count_o == '0 && hit_insns_o == '0));

  assert_idle_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid_i |=> !hit_o);

  assert_hit_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> wrote_q);

  assert_count_span_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (hit_count_o >= CNT_W'(1) && hit_count_o <= CNT_W'(SLOTS)));

  assert_fill_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_held < CNT_W'(SLOTS));

  assert_taken_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_taken_held < TK_W'(MAX_TAKEN));

  assert_close_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    seg_write |=> fill_held == '0);

  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> fill_held == '0);

  assert_flush_miss_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_d && fetch_valid_i) |=> !hit_o);

endmodule

bind trace_cache tc_checker #(
  .SLOTS(SLOTS), .MAX_TAKEN(MAX_TAKEN), .CNT_W(CNT_W), .TK_W(TK_W),
  .BUNDLE_W(BUNDLE_W)
) u_tc_checker (
  .clk             (clk),
  .rst_n           (rst_n),
  .flush_i         (flush_i),
  .fetch_valid_i   (fetch_valid_i),
  .hit_o           (hit_o),
  .hit_count_o     (hit_count_o),
  .hit_insns_o     (hit_insns_o),
  .seg_write       (seg_write),
  .fill_held       (fill_held),
  .fill_taken_held (fill_taken_held)
);

// File: tb/test_trace_cache.sv
`timescale 1ns/1ps
module test_trace_cache;

  localparam int SLOTS = 8;
  localparam int MAXT  = 3;
  localparam int LINES = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         flush_i;
  logic         fill_valid_i;
  logic [31:0]  fill_pc_i;
  logic [31:0]  fill_insn_i;
  logic         fill_taken_i;
  logic [31:0]  fill_next_pc_i;
  logic         fetch_valid_i;
  logic [31:0]  fetch_pc_i;
  logic         hit_o;
  logic [3:0]   hit_count_o;
  logic [255:0] hit_insns_o;
  logic [31:0]  hit_next_pc_o;

  always #2.5 clk = ~clk;

  trace_cache i_trace_cache (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
    .fill_valid_i(fill_valid_i), .fill_pc_i(fill_pc_i),
    .fill_insn_i(fill_insn_i), .fill_taken_i(fill_taken_i),
    .fill_next_pc_i(fill_next_pc_i),
    .fetch_valid_i(fetch_valid_i), .fetch_pc_i(fetch_pc_i),
    .hit_o(hit_o), .hit_count_o(hit_count_o),
    .hit_insns_o(hit_insns_o), .hit_next_pc_o(hit_next_pc_o)
  );

  int vectors = 0;
  int fails   = 0;

  // Bench model of the stored lines and the open segment.
  logic        m_val [LINES];
  logic [31:0] m_tag [LINES];
  int          m_cnt [LINES];
  logic [31:0] m_ins [LINES][SLOTS];
  logic [31:0] m_nxt [LINES];
  int          b_cnt;
  int          b_tk;
  logic [31:0] b_start;
  logic [31:0] b_ins [SLOTS];

  logic         e_hit;
  int           e_cnt;
  logic [255:0] e_ins;
  logic [31:0]  e_nxt;

  function automatic int idx_of(input logic [31:0] pc);
    return int'((pc >> 2) % LINES);
  endfunction

  function automatic logic [31:0] insn_of(input logic [31:0] pc, input int salt);
    return (pc * 32'h9E37_79B1) ^ (32'(salt) << 20) ^ 32'h0000_5A5A;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < LINES; i++) m_val[i] = 1'b0;
    b_cnt = 0;
    b_tk  = 0;
  endtask

  task automatic model_lookup(input logic lv, input logic [31:0] lpc);
    int k;
    k = idx_of(lpc);
    e_ins = '0;
    if (lv && m_val[k] && m_tag[k] == lpc) begin
      e_hit = 1'b1;
      e_cnt = m_cnt[k];
      e_nxt = m_nxt[k];
      for (int s = 0; s < SLOTS; s++)
        if (s < m_cnt[k]) e_ins[s*32 +: 32] = m_ins[k][s];
    end else begin
      e_hit = 1'b0;
      e_cnt = 0;
      e_nxt = '0;
    end
  endtask

  task automatic model_fill(input logic fv, input logic [31:0] pc,
                            input logic [31:0] insn, input logic tk,
                            input logic [31:0] npc, input logic fl);
    int k;
    if (fl) begin
      model_reset();
    end else if (fv) begin
      if (b_cnt == 0) b_start = pc;
      b_ins[b_cnt] = insn;
      b_cnt++;
      if (tk) b_tk++;
      if (b_cnt == SLOTS || b_tk == MAXT) begin
        k = idx_of(b_start);
        m_val[k] = 1'b1;
        m_tag[k] = b_start;
        m_cnt[k] = b_cnt;
        m_nxt[k] = npc;
        for (int s = 0; s < SLOTS; s++) m_ins[k][s] = b_ins[s];
        b_cnt = 0;
        b_tk  = 0;
      end
    end
  endtask

  task automatic compare(input string req);
    vectors++;
    if (hit_o !== e_hit || int'(hit_count_o) != e_cnt ||
        hit_next_pc_o !== e_nxt || hit_insns_o !== e_ins) begin
      fails++;
      $display("FAIL %s: got hit=%0b cnt=%0d next=%h ins=%h ; expected hit=%0b cnt=%0d next=%h ins=%h",
               req, hit_o, hit_count_o, hit_next_pc_o, hit_insns_o,
               e_hit, e_cnt, e_nxt, e_ins);
    end
  endtask

  // One cycle: drive at the falling edge, check 1 ns after the rising edge.
  task automatic step(input logic fv, input logic [31:0] pc, input logic tk,
                      input logic [31:0] npc, input logic lv,
                      input logic [31:0] lpc, input logic fl, input string req);
    logic [31:0] insn;
    insn = insn_of(pc, vectors);
    fill_valid_i   = fv;
    fill_pc_i      = pc;
    fill_insn_i    = insn;
    fill_taken_i   = tk;
    fill_next_pc_i = npc;
    fetch_valid_i  = lv;
    fetch_pc_i     = lpc;
    flush_i        = fl;
    model_lookup(lv, lpc);
    model_fill(fv, pc, insn, tk, npc, fl);
    @(posedge clk);
    #1;
    compare(req);
    @(negedge clk);
  endtask

  task automatic look(input logic [31:0] lpc, input string req);
    step(1'b0, 32'h0, 1'b0, 32'h0, 1'b1, lpc, 1'b0, req);
  endtask

  task automatic fill(input logic [31:0] pc, input logic tk,
                      input logic [31:0] npc, input logic [31:0] lpc,
                      input string req);
    step(1'b1, pc, tk, npc, 1'b1, lpc, 1'b0, req);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got run still active, expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] pc;
    logic [31:0] lpc;
    logic        tk;
    logic        fv;
    logic        lv;
    logic        fl;
    int unsigned seed;
    seed = 32'h1234_5678;
    void'($urandom(seed));

    rst_n = 1'b0;
    flush_i = 1'b0; fill_valid_i = 1'b0; fill_pc_i = '0; fill_insn_i = '0;
    fill_taken_i = 1'b0; fill_next_pc_i = '0; fetch_valid_i = 1'b0;
    fetch_pc_i = '0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    e_hit = 1'b0; e_cnt = 0; e_nxt = '0; e_ins = '0;
    compare("R1 reset");
    @(negedge clk);
    rst_n = 1'b1;
    look(32'h100, "R1 nothing valid");

    // Eight sequential non-taken instructions: partial segment invisible (R6),
    // closing cycle returns old contents (R9), then full line (R4, R3, R7).
    for (int k = 0; k < 7; k++)
      fill(32'h100 + 32'(4*k), 1'b0, 32'h104 + 32'(4*k), 32'h100, "R6 partial");
    fill(32'h11C, 1'b0, 32'h120, 32'h100, "R9 same-cycle write");
    look(32'h100, "R4 eight-slot line");
    look(32'h104, "R2 non-start address");

    // Third taken branch closes a 4-instruction segment (R5, R7).
    fill(32'h244, 1'b1, 32'h300, 32'h244, "R6 partial");
    fill(32'h300, 1'b0, 32'h304, 32'h244, "R6 partial");
    fill(32'h304, 1'b1, 32'h400, 32'h244, "R6 partial");
    fill(32'h400, 1'b1, 32'h500, 32'h0,   "R5 closing");
    look(32'h244, "R5 three taken");
    // Next instruction opens a new segment tagged with its own address (R11).
    fill(32'h500, 1'b1, 32'h600, 32'h500, "R11 partial");
    fill(32'h600, 1'b1, 32'h700, 32'h100, "R3 earlier line");
    fill(32'h700, 1'b1, 32'h800, 32'h500, "R9 same-cycle write");
    look(32'h500, "R11 new tag");
    look(32'h400, "R11 mid-segment address misses");

    // Aliasing start address on index 0 replaces the old line (R8).
    fill(32'h140, 1'b1, 32'h180, 32'h0, "R8 fill");
    fill(32'h180, 1'b1, 32'h1C0, 32'h0, "R8 fill");
    fill(32'h1C0, 1'b1, 32'h200, 32'h0, "R8 fill");
    look(32'h100, "R8 evicted");
    look(32'h140, "R8 replacement");

    // Flush: drop partial segment and the instruction offered with it (R10).
    fill(32'h800, 1'b0, 32'h804, 32'h0, "R10 fill");
    fill(32'h804, 1'b0, 32'h808, 32'h0, "R10 fill");
    step(1'b1, 32'h808, 1'b1, 32'h900, 1'b1, 32'h244, 1'b1, "R10 flush-cycle lookup");
    look(32'h244, "R10 after flush");
    look(32'h140, "R10 after flush");
    fill(32'h900, 1'b1, 32'h904, 32'h0, "R11 fill");
    fill(32'h904, 1'b1, 32'h908, 32'h0, "R11 fill");
    fill(32'h908, 1'b1, 32'h90C, 32'h0, "R11 fill");
    look(32'h900, "R11 segment after flush");
    look(32'h800, "R10 discarded segment");

    // Constrained random mix over a small address pool.
    for (int n = 0; n < 4000; n++) begin
      pc  = ($urandom % 64) << 2;
      lpc = ($urandom % 64) << 2;
      tk  = ($urandom % 4) == 0;
      fv  = ($urandom % 4) != 0;
      lv  = ($urandom % 3) != 0;
      fl  = ($urandom % 97) == 0;
      step(fv, pc, tk, tk ? (($urandom % 64) << 2) : pc + 32'd4, lv, lpc, fl,
           "R2 random");
    end

    summary();
    $finish;
  end

endmodule